// File: doc/BRIEF.md
# Configurable Two-Input Logic Cell

This block is one cell of a fine-grain reconfigurable array. It chooses three operands from a shared pool of sources: the four adjacent cells, the lines of the local bus that spans its block, a constant zero, and its own stored bit. It then forms its result with a single 2:1 multiplexer. One operand drives the multiplexer select. The other two feed the data legs, and each of them can be inverted first. With the right operand and inversion choices, the cell can produce every Boolean function of two variables.

The result leaves the cell in one of two ways. It can go straight out, or it can pass through a one-bit register first; a mode bit picks which. A host port loads the configuration word and can write or read the register. When the protect bit is set, the register is no longer updated by the cell's own result, and only the host can change it.

Top module: `flexcell`

## Requirements
- R1: After reset, the configuration word is 0, the register is 0, `cell_out` is 0 and `host_rdata` is 0 at both host addresses.
- R2: A host write with `host_addr`=0 loads `host_wdata` into the configuration word at the next clock edge. While `host_addr`=0, `host_rdata` shows that word. The layout is: bits [2:0] select source, [5:3] low-leg source, [8:6] high-leg source, bit 9 low-leg invert, bit 10 high-leg invert, bit 11 registered mode, bit 12 protect.
- R3: The source codes are: 0 constant zero, 1 north, 2 east, 3 south, 4 west, 5 and 6 bus lines 0 and 1, and 7 the cell's own register.
- R4: The function result is (select operand ? high leg XOR high-invert : low leg XOR low-invert), and every one of the 16 two-input functions can be configured.
- R5: With bit 11 clear, `cell_out` is the function result in the same cycle. With bit 11 set, `cell_out` is the register.
- R6: With protect clear and no host register write, the register takes the function result at every clock edge.
- R7: With protect set, the register holds its value across clock edges and input changes, unless the host writes it.
- R8: A host write with `host_addr`=1 loads `host_wdata[0]` into the register. While `host_addr`=1, `host_rdata` shows the register in bit 0 and zeros in every other bit.
- R9: A host register write and a cell update in the same cycle resolve in favour of the host value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nb_n | input | 1 | North neighbour input |
| nb_e | input | 1 | East neighbour input |
| nb_s | input | 1 | South neighbour input |
| nb_w | input | 1 | West neighbour input |
| lane_in | input | LANES (2) | Block-local bus lines |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 1 | Host address: 0 configuration, 1 register |
| host_wdata | input | 13 | Host write data |
| host_rdata | output | 13 | Host read data for `host_addr` |
| cell_out | output | 1 | Cell result |

## Verification
The hardest case to reach from the ports is a collision: a host register write arriving in the same cycle as a cell update that would load the opposite value. To set it up, the bench configures the low leg as an inverted constant, so the function result is always 1. It then writes a 0 to the register in an unprotected, registered configuration and checks that the 0 appears and the 1 returns one cycle later. The case where the register selects itself is reached by routing the register back through an inverted leg, so that it toggles each cycle. A separate sweep builds all sixteen truth tables from a rule and compares `cell_out` to the table directly, without using the bench model.

// File: rtl/cellpkg.sv
package cellpkg;

    typedef enum logic {
        HA_CFG = 1'b0,
        HA_REG = 1'b1
    } host_addr_e;

    // constant zero + four neighbours + bus lines + own register
    function automatic int src_count(input int lanes);
        return 6 + lanes;
    endfunction

    function automatic int src_width(input int lanes);
        return $clog2(6 + lanes);
    endfunction

endpackage

// File: rtl/cell_src_mux.sv
module cell_src_mux #(
    parameter int NSRC  = 8,
    parameter int SRC_W = 3
) (
    input  logic [NSRC-1:0]  src_vec,
    input  logic [SRC_W-1:0] sel,
    output logic             y
);

    always_comb begin
        y = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SRC_W'(i)) begin
                y = src_vec[i];
            end
        end
    end

endmodule

// File: rtl/cell_mux_core.sv
module cell_mux_core (
    input  logic clk,
    input  logic rst_n,
    input  logic x_sel,
    input  logic x_lo,
    input  logic x_hi,
    input  logic inv_lo,
    input  logic inv_hi,
    output logic f
);

    logic leg_lo;
    logic leg_hi;

    always_comb begin
        leg_lo = x_lo ^ inv_lo;
        leg_hi = x_hi ^ inv_hi;
        f      = x_sel ? leg_hi : leg_lo;
    end

    // R4
    same_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_lo == x_hi && inv_lo == inv_hi) |-> (f == (x_lo ^ inv_lo)));

endmodule

// File: rtl/cell_state.sv
module cell_state
    import cellpkg::*;
#(
    parameter int SRC_W = 3,
    localparam int CFG_W = 3 * SRC_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_addr,
    input  logic [CFG_W-1:0] host_wdata,
    input  logic             f_in,
    output logic [CFG_W-1:0] cfg_o,
    output logic             reg_o
);

    typedef struct packed {
        logic             protect;
        logic             seq;
        logic             inv_hi;
        logic             inv_lo;
        logic [SRC_W-1:0] sel_hi;
        logic [SRC_W-1:0] sel_lo;
        logic [SRC_W-1:0] sel_x;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic q;
    } state_t;

    state_t state_d;
    state_t state_q;
    logic   wr_cfg;
    logic   wr_reg;

    always_comb begin
        wr_cfg  = host_we && (host_addr == HA_CFG);
        wr_reg  = host_we && (host_addr == HA_REG);
        state_d = state_q;
        if (wr_cfg) begin
            state_d.cfg = cfg_t'(host_wdata);
        end
        if (wr_reg) begin
            state_d.q = host_wdata[0];
        end else if (!state_q.cfg.protect) begin
            state_d.q = f_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_o = state_q.cfg;
    assign reg_o = state_q.q;

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == HA_CFG) |=> (cfg_o == $past(host_wdata)));

    // R6
    track_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.cfg.protect && !(host_we && host_addr == HA_REG)) |=> (reg_o == $past(f_in)));

    // R7
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cfg.protect && !(host_we && host_addr == HA_REG)) |=> $stable(reg_o));

    // R9
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == HA_REG) |=> (reg_o == $past(host_wdata[0])));

endmodule

// File: rtl/flexcell.sv
module flexcell
    import cellpkg::*;
#(
    parameter int LANES = 2,
    localparam int NSRC  = src_count(LANES),
    localparam int SRC_W = src_width(LANES),
    localparam int CFG_W = 3 * SRC_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nb_n,
    input  logic             nb_e,
    input  logic             nb_s,
    input  logic             nb_w,
    input  logic [LANES-1:0] lane_in,
    input  logic             host_we,
    input  logic             host_addr,
    input  logic [CFG_W-1:0] host_wdata,
    output logic [CFG_W-1:0] host_rdata,
    output logic             cell_out
);

    localparam int NOPS = 3;

    logic [CFG_W-1:0] cfg_w;
    logic             reg_w;
    logic             f_w;
    logic [NSRC-1:0]  src_vec;
    logic [NOPS-1:0]  opnd;
    logic             cfg_seq;
    logic             cfg_protect;
    logic             cfg_inv_lo;
    logic             cfg_inv_hi;

    // source order follows the code table: zero, N, E, S, W, lanes, own register
    assign src_vec = {reg_w, lane_in, nb_w, nb_s, nb_e, nb_n, 1'b0};

    assign cfg_inv_lo  = cfg_w[3*SRC_W];
    assign cfg_inv_hi  = cfg_w[3*SRC_W+1];
    assign cfg_seq     = cfg_w[3*SRC_W+2];
    assign cfg_protect = cfg_w[3*SRC_W+3];

    // operand 0 drives the select, 1 the low leg, 2 the high leg
    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        cell_src_mux #(
            .NSRC  (NSRC),
            .SRC_W (SRC_W)
        ) u_src (
            .src_vec (src_vec),
            .sel     (cfg_w[g*SRC_W +: SRC_W]),
            .y       (opnd[g])
        );
    end

    cell_mux_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_sel  (opnd[0]),
        .x_lo   (opnd[1]),
        .x_hi   (opnd[2]),
        .inv_lo (cfg_inv_lo),
        .inv_hi (cfg_inv_hi),
        .f      (f_w)
    );

    cell_state #(
        .SRC_W (SRC_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .f_in       (f_w),
        .cfg_o      (cfg_w),
        .reg_o      (reg_w)
    );

    always_comb begin
        cell_out   = cfg_seq ? reg_w : f_w;
        host_rdata = (host_addr == HA_REG) ? {{(CFG_W-1){1'b0}}, reg_w} : cfg_w;
    end

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seq && cfg_protect && !host_we) |=> $stable(cell_out));

endmodule

// File: tb/flexcell_bench.sv
module flexcell_bench;

    localparam int LANES = 2;
    localparam int CFG_W = 13;

    typedef struct {
        logic             out;
        logic [CFG_W-1:0] rd;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             nb_n = 1'b0, nb_e = 1'b0, nb_s = 1'b0, nb_w = 1'b0;
    logic [LANES-1:0] lane_in = '0;
    logic             host_we = 1'b0;
    logic             host_addr = 1'b0;
    logic [CFG_W-1:0] host_wdata = '0;
    logic [CFG_W-1:0] host_rdata;
    logic             cell_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sbq[$];

    logic [CFG_W-1:0] m_cfg = '0;
    logic             m_q   = 1'b0;

    always #5 clk = ~clk;

    flexcell #(.LANES(LANES)) u_flexcell (
        .clk        (clk),
        .rst_n      (rst_n),
        .nb_n       (nb_n),
        .nb_e       (nb_e),
        .nb_s       (nb_s),
        .nb_w       (nb_w),
        .lane_in    (lane_in),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cell_out   (cell_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Requirement-level model: field layout of R2, codes of R3, function of R4
    function automatic logic pick(input logic [2:0] code, input logic [3:0] nb,
                                  input logic [LANES-1:0] ln, input logic q);
        logic [7:0] v;
        v = {q, ln, nb, 1'b0};
        return v[code];
    endfunction

    function automatic logic fmodel(input logic [CFG_W-1:0] c, input logic [3:0] nb,
                                    input logic [LANES-1:0] ln, input logic q);
        logic s, lo, hi;
        s  = pick(c[2:0], nb, ln, q);
        lo = pick(c[5:3], nb, ln, q) ^ c[9];
        hi = pick(c[8:6], nb, ln, q) ^ c[10];
        return s ? hi : lo;
    endfunction

    // driver: called just after a falling edge; pushes what the next rising edge yields
    task automatic step(input bit we, input bit addr, input logic [CFG_W-1:0] wd,
                        input logic [3:0] nb, input logic [LANES-1:0] ln, input string req);
        logic f_now, nq;
        exp_t e;
        host_we = we; host_addr = addr; host_wdata = wd;
        {nb_w, nb_s, nb_e, nb_n} = nb;
        lane_in = ln;
        f_now = fmodel(m_cfg, nb, ln, m_q);
        if (we && addr)        nq = wd[0];
        else if (m_cfg[12])    nq = m_q;
        else                   nq = f_now;
        if (we && !addr) m_cfg = wd;
        m_q = nq;
        e.out = m_cfg[11] ? m_q : fmodel(m_cfg, nb, ln, m_q);
        e.rd  = addr ? {{(CFG_W-1){1'b0}}, m_q} : m_cfg;
        e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [CFG_W-1:0] mk(input bit prot, input bit seq, input bit ih,
                                            input bit il, input logic [2:0] sh,
                                            input logic [2:0] sl, input logic [2:0] sx);
        return {prot, seq, ih, il, sh, sl, sx};
    endfunction

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(cell_out === e.out, {e.req, " cell_out"}, int'(cell_out), int'(e.out));
                check(host_rdata === e.rd, {e.req, " host_rdata"}, int'(host_rdata), int'(e.rd));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [CFG_W-1:0] c;
        logic [2:0] sl, sh;
        bit il, ih;

        // R1 reset state
        repeat (3) @(negedge clk);
        host_addr = 1'b0; #1;
        check(cell_out === 1'b0, "R1 out", int'(cell_out), 0);
        check(host_rdata === '0, "R1 cfg", int'(host_rdata), 0);
        host_addr = 1'b1; #1;
        check(host_rdata === '0, "R1 reg", int'(host_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 configuration write and readback
        step(1, 0, 13'h0ABC, 4'h0, 2'b00, "R2 write");
        step(0, 0, '0, 4'h5, 2'b01, "R2 readback");
        step(1, 0, 13'h1555 & 13'h07FF, 4'hA, 2'b10, "R2 rewrite");

        // R3 each source code routed to the low leg
        for (int code = 1; code < 7; code++) begin
            c = mk(0, 0, 0, 0, 3'd0, 3'(code), 3'd0);
            step(1, 0, c, 4'h0, 2'b00, "R3 cfg");
            step(0, 0, '0, (code <= 4) ? 4'(1 << (code - 1)) : 4'h0,
                 (code > 4) ? 2'(1 << (code - 5)) : 2'b00, "R3 one-hot");
            step(0, 0, '0, (code <= 4) ? ~4'(1 << (code - 1)) : 4'hF,
                 (code > 4) ? ~2'(1 << (code - 5)) : 2'b11, "R3 one-cold");
        end
        // R3 code 0 is constant zero
        step(1, 0, mk(0, 0, 0, 0, 3'd0, 3'd0, 3'd0), 4'hF, 2'b11, "R3 zero");

        // R8 host register write and readback, protected so it stays
        step(1, 0, mk(1, 0, 0, 0, 3'd0, 3'd7, 3'd0), 4'h0, 2'b00, "R8 cfg");
        step(1, 1, 13'h1FFF, 4'h0, 2'b00, "R8 write one");
        step(0, 1, '0, 4'h0, 2'b00, "R8 readback");
        check(host_rdata === 13'h0001, "R8 upper bits zero", int'(host_rdata), 1);
        step(1, 1, 13'h0000, 4'h0, 2'b00, "R8 write zero");

        // R4 all sixteen functions of a=north, b=east, checked against the truth table
        for (int tt = 0; tt < 16; tt++) begin
            if (tt[0] == tt[1]) begin sl = 3'd0; il = tt[0]; end
            else                begin sl = 3'd2; il = tt[0]; end
            if (tt[2] == tt[3]) begin sh = 3'd0; ih = tt[2]; end
            else                begin sh = 3'd2; ih = tt[2]; end
            step(1, 0, mk(0, 0, ih, il, sh, sl, 3'd1), 4'h0, 2'b00, "R4 cfg");
            for (int ab = 0; ab < 4; ab++) begin
                step(0, 0, '0, {2'b00, 1'(ab & 1), 1'(ab >> 1)}, 2'b00, "R4 model");
                check(cell_out === tt[ab], "R4 truth table", int'(cell_out), tt[ab]);
            end
        end

        // R5/R6 registered mode lags the input by one edge
        step(1, 0, mk(0, 1, 0, 0, 3'd0, 3'd1, 3'd0), 4'h0, 2'b00, "R5 cfg");
        step(0, 0, '0, 4'h1, 2'b00, "R5 capture");
        step(0, 0, '0, 4'h0, 2'b00, "R6 capture zero");
        step(0, 0, '0, 4'h1, 2'b00, "R6 capture one");
        // R6 feedback: register through inverted low leg toggles each edge
        step(1, 0, mk(0, 1, 0, 1, 3'd0, 3'd7, 3'd0), 4'h0, 2'b00, "R6 toggle cfg");
        for (int k = 0; k < 4; k++) step(0, 1, '0, 4'h0, 2'b00, "R6 toggle");

        // R7 protected register holds while inputs move
        step(1, 0, mk(1, 1, 0, 0, 3'd0, 3'd1, 3'd0), 4'h0, 2'b00, "R7 cfg");
        step(1, 1, 13'h0001, 4'h0, 2'b00, "R7 preset");
        for (int k = 0; k < 4; k++) begin
            step(0, 1, '0, 4'(k * 5), 2'(k), "R7 hold");
            check(cell_out === 1'b1, "R7 held value", int'(cell_out), 1);
        end

        // R9 host write of 0 while the cell result is constant 1
        step(1, 0, mk(0, 1, 0, 1, 3'd0, 3'd0, 3'd0), 4'h0, 2'b00, "R9 cfg");
        step(0, 1, '0, 4'h0, 2'b00, "R9 settle");
        step(1, 1, 13'h0000, 4'h0, 2'b00, "R9 collision");
        check(cell_out === 1'b0, "R9 host value wins", int'(cell_out), 0);
        step(0, 1, '0, 4'h0, 2'b00, "R9 resume");
        check(cell_out === 1'b1, "R9 cell resumes", int'(cell_out), 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule